// File: doc/BRIEF.md
# Rational Energy Pulse Rate Scaler

This block turns streams of unit energy pulses into slower output pulse streams whose rate is a programmable fraction of the input rate. Each input pulse stands for one least significant bit of energy accumulated elsewhere. Four pulse sources feed the block: active power, reactive power, apparent power and current rms. Each output channel picks one of them through a 2-bit select. A shared routing bit decides which channel of an even/odd pair receives apparent power and which receives current rms when the select names the apparent/rms group.

Every channel scales its selected pulse stream by NUM/DEN with a phase accumulator. Each input pulse adds NUM. When the sum reaches DEN, DEN is subtracted and one single-cycle output event is emitted. Register values are sanitised before use: a zero reads as one, and a numerator above the denominator is clamped so that the ratio is exactly one. Each output event sets a sticky per-channel flag. When the matching enable is set, a flagged channel raises the shared interrupt request until software clears the flag.

Top module: `energy_pulse_scaler`

## Requirements
- R1: Per channel, select code 00 takes active pulses, 01 takes reactive pulses, and 10 or 11 takes the apparent/rms group; pulses of unselected sources have no effect on that channel's output.
- R2: With route_swap = 0, even channels in the group take apparent pulses and odd channels take rms pulses; with route_swap = 1 the two are exchanged, so an even/odd pair never both take apparent pulses.
- R3: After the accumulator is cleared, k selected input pulses produce exactly floor(k × NUM/DEN) output pulses. Each output pulse is high for one cycle, in the cycle after the input pulse that completes it.
- R4: A NUM or DEN value of 0 is used as 1.
- R5: When the sanitised NUM exceeds the sanitised DEN, the ratio is exactly 1: every input pulse produces one output pulse.
- R6: A change of NUM, DEN or the select clears the channel's accumulator at the next clock edge; an input pulse in that same cycle is dropped.
- R7: While a channel's disable bit is 1, it emits no output pulse and sets no flag; its accumulator keeps advancing.
- R8: Each output pulse sets the channel's flag one cycle later. The flag stays set until flag_clear is pulsed, and a clear in the same cycle as a set leaves the flag set.
- R9: irq is 1 exactly when some channel has both its flag and its irq_en bit at 1.
- R10: After reset, out_pulse, flag and irq are all 0 and every accumulator is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_pulse | input | 1 | Active energy unit pulse, one cycle wide |
| react_pulse | input | 1 | Reactive energy unit pulse |
| apparent_pulse | input | 1 | Apparent energy unit pulse |
| irms_pulse | input | 1 | Current rms unit pulse |
| route_swap | input | 1 | Apparent/rms routing across even/odd channels |
| src_sel | input | 2*NCH | Source select, 2 bits per channel |
| ratio_num | input | RW*NCH | Numerator per channel |
| ratio_den | input | RW*NCH | Denominator per channel |
| ch_disable | input | NCH | Output suppression per channel |
| irq_en | input | NCH | Interrupt enable per channel |
| flag_clear | input | NCH | One-cycle flag clear per channel |
| out_pulse | output | NCH | Scaled output event per channel |
| flag | output | NCH | Sticky output flag per channel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every source pulse is a single-cycle strobe. They also assume that the control inputs change only between clock edges, so that an output event can always be traced to an input pulse in the cycle before it. The bench drives each source pulse for exactly one cycle with an idle cycle after it, and it changes registers only at falling edges. Between table vectors it resets the block, or it changes the configuration and then waits a settling cycle before the next pulse, so that each count starts from an empty accumulator.

// File: rtl/eps_pkg.sv
// Shared types for the rational energy pulse rate scaler.
// Assumes source pulses are single-cycle strobes.
package eps_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_ACTIVE   = 2'b00,
        SRC_REACTIVE = 2'b01,
        SRC_GROUP_LO = 2'b10,
        SRC_GROUP_HI = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic act;
        logic react;
        logic apparent;
        logic irms;
    } src_pulses_t;
endpackage

// File: rtl/eps_src_mux.sv
// Picks one of four unit-pulse sources for one channel.
// Group codes (1x) route apparent or rms by channel parity and route_swap,
// so an even/odd channel pair never both take apparent pulses.
module eps_src_mux
    import eps_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             route_swap,
    input  src_pulses_t      srcs,
    output logic             pulse
);
    localparam bit IS_ODD = (CH_IDX % 2) == 1;

    logic takes_apparent;
    assign takes_apparent = (route_swap == IS_ODD);

    // Purpose: decode the select into the chosen source pulse.
    always_comb begin
        case (src_sel_e'(sel))
            SRC_ACTIVE:   pulse = srcs.act;
            SRC_REACTIVE: pulse = srcs.react;
            default:      pulse = takes_apparent ? srcs.apparent : srcs.irms;
        endcase
    end
endmodule

// File: rtl/eps_ratio_core.sv
// Fractional rate scaler for one channel: a phase accumulator adds the
// sanitised numerator per input pulse and emits an event when the sum reaches
// the denominator. Zero registers read as 1; num > den clamps to ratio 1.
// Any change of num, den or select clears the accumulator at the next edge.
module eps_ratio_core #(
    parameter int RW    = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RW-1:0]    num,
    input  logic [RW-1:0]    den,
    input  logic [SEL_W-1:0] sel,
    input  logic             in_pulse,
    input  logic             out_enable,
    output logic             out_evt
);
    localparam int AW    = RW + 1;
    localparam int CFG_W = 2 * RW + SEL_W;

    logic [RW-1:0]    num_nz, den_nz, num_eff;
    logic [CFG_W-1:0] cfg_now, cfg_q;
    logic             cfg_changed;
    logic [AW-1:0]    acc, sum;
    logic             reach;

    // Purpose: sanitise the ratio registers (zero -> 1, clamp num to den).
    always_comb begin
        num_nz  = (num == '0) ? RW'(1) : num;
        den_nz  = (den == '0) ? RW'(1) : den;
        num_eff = (num_nz > den_nz) ? den_nz : num_nz;
    end

    assign cfg_now     = {num, den, sel};
    assign cfg_changed = (cfg_now != cfg_q);
    assign sum         = acc + {1'b0, num_eff};
    assign reach       = (sum >= {1'b0, den_nz});

    // Purpose: remember the last configuration to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    // Purpose: advance the phase accumulator and emit one-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            out_evt <= 1'b0;
        end else if (cfg_changed) begin
            acc     <= '0;
            out_evt <= 1'b0;
        end else if (in_pulse) begin
            if (reach) begin
                acc     <= sum - {1'b0, den_nz};
                out_evt <= out_enable;
            end else begin
                acc     <= sum;
                out_evt <= 1'b0;
            end
        end else begin
            out_evt <= 1'b0;
        end
    end
endmodule

// File: rtl/eps_flag_ctrl.sv
// Sticky per-channel flags set by output events, cleared by software strobes
// (set wins over clear), and a combined interrupt request gated by enables.
module eps_flag_ctrl #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] flag,
    output logic           irq
);
    // Purpose: hold each flag until cleared, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= evt | (flag & ~clr);
    end

    // Purpose: raise the request while any enabled flag is set.
    assign irq = |(flag & en);
endmodule

// File: rtl/energy_pulse_scaler.sv
// Top of the rational energy pulse rate scaler: NCH channels, each with a
// source mux and a ratio core, sharing one flag/interrupt controller.
// Assumes source pulses are single-cycle strobes and controls are static
// between edges.
module energy_pulse_scaler
    import eps_pkg::*;
#(
    parameter int NCH = 2,
    parameter int RW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_pulse,
    input  logic              react_pulse,
    input  logic              apparent_pulse,
    input  logic              irms_pulse,
    input  logic              route_swap,
    input  logic [2*NCH-1:0]  src_sel,
    input  logic [RW*NCH-1:0] ratio_num,
    input  logic [RW*NCH-1:0] ratio_den,
    input  logic [NCH-1:0]    ch_disable,
    input  logic [NCH-1:0]    irq_en,
    input  logic [NCH-1:0]    flag_clear,
    output logic [NCH-1:0]    out_pulse,
    output logic [NCH-1:0]    flag,
    output logic              irq
);
    src_pulses_t    srcs;
    logic [NCH-1:0] evt;

    assign srcs = '{act: act_pulse, react: react_pulse,
                    apparent: apparent_pulse, irms: irms_pulse};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel_pulse;

        eps_src_mux #(.CH_IDX(c)) u_mux (
            .sel        (src_sel[SEL_W*c +: SEL_W]),
            .route_swap (route_swap),
            .srcs       (srcs),
            .pulse      (sel_pulse)
        );

        eps_ratio_core #(.RW(RW), .SEL_W(SEL_W)) u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .num        (ratio_num[RW*c +: RW]),
            .den        (ratio_den[RW*c +: RW]),
            .sel        (src_sel[SEL_W*c +: SEL_W]),
            .in_pulse   (sel_pulse),
            .out_enable (!ch_disable[c]),
            .out_evt    (evt[c])
        );
    end

    assign out_pulse = evt;

    eps_flag_ctrl #(.NCH(NCH)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (flag_clear),
        .en    (irq_en),
        .flag  (flag),
        .irq   (irq)
    );
endmodule

// File: rtl/eps_scaler_checker.sv
// Port-level properties of energy_pulse_scaler, bound to every instance.
module eps_scaler_checker #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           act_pulse,
    input logic           react_pulse,
    input logic           apparent_pulse,
    input logic           irms_pulse,
    input logic [NCH-1:0] ch_disable,
    input logic [NCH-1:0] irq_en,
    input logic [NCH-1:0] flag_clear,
    input logic [NCH-1:0] out_pulse,
    input logic [NCH-1:0] flag,
    input logic           irq
);
    logic any_src;
    assign any_src = act_pulse | react_pulse | apparent_pulse | irms_pulse;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_out_needs_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_pulse[c] |-> $past(any_src));
        assert_disable_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ch_disable[c]) |-> !out_pulse[c]);
        assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_pulse[c] |=> flag[c]);
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[c] && !flag_clear[c]) |=> flag[c]);
        assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clear[c] && !out_pulse[c]) |=> !flag[c]);
        assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag[c]) && irq_en[c]) |-> irq);
    end

    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == '0) |-> !irq);
endmodule

bind energy_pulse_scaler eps_scaler_checker #(.NCH(NCH)) u_eps_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .act_pulse      (act_pulse),
    .react_pulse    (react_pulse),
    .apparent_pulse (apparent_pulse),
    .irms_pulse     (irms_pulse),
    .ch_disable     (ch_disable),
    .irq_en         (irq_en),
    .flag_clear     (flag_clear),
    .out_pulse      (out_pulse),
    .flag           (flag),
    .irq            (irq)
);

// File: tb/test_energy_pulse_scaler.sv
module test_energy_pulse_scaler;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int RW  = 16;

    typedef struct packed {
        logic [15:0] num;
        logic [15:0] den;
        logic [15:0] n_in;
    } vec_t;

    // Ratio vectors: zeros, clamp, fine fractions, unity.
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{16'd1,     16'd3,     16'd30},
        '{16'd0,     16'd0,     16'd10},
        '{16'd5,     16'd2,     16'd12},
        '{16'd0,     16'd7,     16'd21},
        '{16'd3,     16'd0,     16'd9},
        '{16'd65535, 16'd65535, 16'd5},
        '{16'd1000,  16'd65535, 16'd200},
        '{16'd7,     16'd16,    16'd50},
        '{16'd40000, 16'd50000, 16'd40},
        '{16'd2,     16'd5,     16'd23}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        src = '0;  // 0 act, 1 react, 2 apparent, 3 irms
    logic              route_swap = 1'b0;
    logic [2*NCH-1:0]  src_sel = '0;
    logic [RW*NCH-1:0] ratio_num = '0;
    logic [RW*NCH-1:0] ratio_den = '0;
    logic [NCH-1:0]    ch_disable = '0;
    logic [NCH-1:0]    irq_en = '0;
    logic [NCH-1:0]    flag_clear = '0;
    logic [NCH-1:0]    out_pulse;
    logic [NCH-1:0]    flag;
    logic              irq;

    int checks = 0;
    int failures = 0;
    int cnt0 = 0;
    int cnt1 = 0;
    bit done = 0;

    energy_pulse_scaler #(.NCH(NCH), .RW(RW)) i_energy_pulse_scaler (
        .clk(clk), .rst_n(rst_n),
        .act_pulse(src[0]), .react_pulse(src[1]),
        .apparent_pulse(src[2]), .irms_pulse(src[3]),
        .route_swap(route_swap), .src_sel(src_sel),
        .ratio_num(ratio_num), .ratio_den(ratio_den),
        .ch_disable(ch_disable), .irq_en(irq_en), .flag_clear(flag_clear),
        .out_pulse(out_pulse), .flag(flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (out_pulse[0]) cnt0++;
        if (out_pulse[1]) cnt1++;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fire(input int idx, input int times);
        for (int i = 0; i < times; i++) begin
            src[idx] = 1'b1;
            @(negedge clk);
            src[idx] = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic zero_counts();
        @(negedge clk);
        cnt0 = 0;
        cnt1 = 0;
    endtask

    function automatic longint expect_count(input longint num, input longint den, input longint k);
        longint n, d;
        d = (den == 0) ? 1 : den;
        n = (num == 0) ? 1 : num;
        if (n > d) n = d;
        return (k * n) / d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        do_reset();
        check("R10 out_pulse after reset", out_pulse, 0);
        check("R10 flag after reset", flag, 0);
        check("R10 irq after reset", irq, 0);

        // R3 R4 R5: ratio table on channel 0, active source (code 00)
        for (int v = 0; v < NV; v++) begin
            do_reset();
            src_sel[1:0]    = 2'b00;
            ratio_num[15:0] = VEC[v].num;
            ratio_den[15:0] = VEC[v].den;
            repeat (2) @(negedge clk);
            zero_counts();
            fire(0, int'(VEC[v].n_in));
            repeat (2) @(negedge clk);
            check($sformatf("R3 R4 R5 vector %0d num=%0d den=%0d", v, VEC[v].num, VEC[v].den),
                  cnt0, expect_count(VEC[v].num, VEC[v].den, VEC[v].n_in));
        end

        // R3: one-cycle output, one cycle after the input pulse
        do_reset();
        ratio_num[15:0] = 16'd1; ratio_den[15:0] = 16'd1;
        repeat (2) @(negedge clk);
        src[0] = 1'b1;
        @(negedge clk);
        src[0] = 1'b0;
        check("R3 output in cycle after input", out_pulse[0], 1);
        @(negedge clk);
        check("R3 output lasts one cycle", out_pulse[0], 0);

        // R1: select 01 takes reactive only
        do_reset();
        src_sel[1:0] = 2'b01;
        repeat (2) @(negedge clk);
        zero_counts();
        fire(0, 3);
        fire(1, 2);
        fire(2, 2);
        check("R1 select 01 counts reactive only", cnt0, 2);

        // R2: routing of the apparent/rms group
        do_reset();
        src_sel = 4'b11_10;
        route_swap = 1'b0;
        repeat (2) @(negedge clk);
        zero_counts();
        fire(2, 3);
        fire(3, 2);
        check("R2 swap=0 even channel gets apparent", cnt0, 3);
        check("R2 swap=0 odd channel gets rms", cnt1, 2);
        route_swap = 1'b1;
        zero_counts();
        fire(2, 1);
        fire(3, 4);
        check("R2 swap=1 even channel gets rms", cnt0, 4);
        check("R2 swap=1 odd channel gets apparent", cnt1, 1);
        route_swap = 1'b0;

        // R6: configuration change clears the accumulator
        do_reset();
        src_sel = '0;
        ratio_num[15:0] = 16'd1; ratio_den[15:0] = 16'd3;
        repeat (2) @(negedge clk);
        zero_counts();
        fire(0, 2);
        ratio_num[15:0] = 16'd2;
        repeat (2) @(negedge clk);
        fire(0, 1);
        check("R6 accumulator cleared by num change", cnt0, 0);
        fire(0, 1);
        check("R6 second pulse after clear", cnt0, 1);
        ratio_num[15:0] = 16'd3; ratio_den[15:0] = 16'd3;
        src[0] = 1'b1;
        @(negedge clk);
        src[0] = 1'b0;
        @(negedge clk);
        check("R6 pulse in change cycle dropped", cnt0, 1);
        fire(0, 1);
        check("R6 pulse after change counted", cnt0, 2);

        // R7: disable suppresses pulses and flag
        do_reset();
        ratio_num[15:0] = 16'd1; ratio_den[15:0] = 16'd1;
        ch_disable[0] = 1'b1;
        repeat (2) @(negedge clk);
        zero_counts();
        fire(0, 3);
        @(negedge clk);
        check("R7 disabled channel emits nothing", cnt0, 0);
        check("R7 disabled channel sets no flag", flag[0], 0);
        ch_disable[0] = 1'b0;
        fire(0, 1);
        check("R7 re-enabled channel emits", cnt0, 1);

        // R8 R9: flag and interrupt
        do_reset();
        irq_en = '0;
        repeat (2) @(negedge clk);
        fire(0, 1);
        check("R8 flag set by output", flag[0], 1);
        check("R9 irq low while disabled", irq, 0);
        irq_en[0] = 1'b1;
        #1;
        check("R9 irq high with enable", irq, 1);
        @(negedge clk);
        flag_clear[0] = 1'b1;
        @(negedge clk);
        flag_clear[0] = 1'b0;
        check("R8 flag cleared", flag[0], 0);
        check("R9 irq low after clear", irq, 0);
        fire(0, 1);
        src[0] = 1'b1;
        @(negedge clk);
        src[0] = 1'b0;
        flag_clear[0] = 1'b1;
        @(negedge clk);
        flag_clear[0] = 1'b0;
        check("R8 set wins over clear", flag[0], 1);
        check("R9 irq held with set flag", irq, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule